// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block models the device end of a serial keyboard, seen from the host through a byte queue. Key events come in as an 8-bit code, a press or release flag and a one-hot lock-key select. They are encoded into make or break bytes and queued. Host command bytes are decoded by a small command engine. That engine answers identification and layout requests with fixed multi-byte replies. It also swallows the argument byte that follows an indicator-light command.

The host drains the queue through a show-ahead pop port. The oldest byte is always visible on `pop_data`, and a pop strobe advances past it. Toggling lock keys pass through a per-key two-bit filter, so each physical press-and-release pair of a lock key reaches the host as a single transition.

Top module: `keyresp_top`

## Requirements
- R1: An accepted key event is appended to the queue. `data_avail` is high and the oldest byte shows on `pop_data` from the cycle after the enqueue, in first-in first-out order.
- R2: A byte offered while the queue holds DEPTH bytes is dropped without changing the stored bytes.
- R3: With the queue empty, `pop_data` reads 0x00, `data_avail` is low and a pop changes nothing.
- R4: After a pop, `data_avail` stays high while bytes remain and falls when the last byte is removed.
- R5: A release is queued as the key code with bit 7 set, and a press is queued with bit 7 cleared, whatever bit 7 of the input code was.
- R6: Host byte 0x01 empties the queue and leaves exactly 0xFF, 0x04, 0x7F in it, in that order.
- R7: Host byte 0x07 or 0x0F empties the queue and leaves exactly 0xFE, 0x21 in it, in that order.
- R8: After host byte 0x0E, the next host byte is discarded whatever its value, and decoding then resumes normally.
- R9: Any other host byte leaves the queue unchanged.
- R10: Each lock key keeps a 2-bit state. A press flips bit 0 and is dropped when the state becomes 2. A release flips bit 1 and is dropped when the state becomes 3. Each lock key has its own state.
- R11: While `enable` is low, host bytes have no effect.
- R12: Reset empties the queue, leaves the light-argument mode and returns every lock-key state to 0.
- R13: A key event that arrives in the same cycle as a host byte that loads a reply is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Host command decoding enabled |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 8 | Translated key code |
| key_release | input | 1 | 1 = release, 0 = press |
| key_lock | input | NUM_LOCKS | One-hot lock-key select, all zero for ordinary keys |
| host_valid | input | 1 | Host byte strobe |
| host_byte | input | 8 | Command byte from host |
| pop | input | 1 | Advance past the oldest queued byte |
| pop_data | output | 8 | Oldest queued byte, 0x00 when empty |
| data_avail | output | 1 | Queue holds at least one byte |

## Verification
Every stimulus here is taken on one rising edge. The queue state it changes is registered on that edge. `pop_data` and `data_avail` are driven combinationally from that state, so each result is due exactly one cycle after its stimulus. The bench drives each stimulus at a falling edge and removes it at the next falling edge. It samples both outputs at that second falling edge, a half cycle after the register update, so no sample races a clock edge. Replies loaded by host commands follow the same one-cycle rule. Their later bytes are read one pop per cycle.

// File: rtl/keyresp_pkg.sv
package keyresp_pkg;
   typedef logic [7:0] kr_byte_t;

   localparam kr_byte_t KR_CMD_IDENT   = 8'h01;
   localparam kr_byte_t KR_CMD_LIGHTS  = 8'h0E;
   localparam kr_byte_t KR_CMD_LAYOUT0 = 8'h07;
   localparam kr_byte_t KR_CMD_LAYOUT1 = 8'h0F;

   localparam kr_byte_t KR_ID_B0  = 8'hFF;
   localparam kr_byte_t KR_ID_B1  = 8'h04;
   localparam kr_byte_t KR_ID_B2  = 8'h7F;
   localparam kr_byte_t KR_LAY_B0 = 8'hFE;
   localparam kr_byte_t KR_LAY_B1 = 8'h21;

   localparam int KR_REPLY_MAX = 3;
   localparam int KR_LEN_W     = $clog2(KR_REPLY_MAX + 1);
endpackage

// File: rtl/keyresp_fifo.sv
module keyresp_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8,
   parameter int RMAX  = 3,
   parameter int LW    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push,
   input  logic [W-1:0]          push_data,
   input  logic                  pop,
   input  logic                  load,
   input  logic [LW-1:0]         load_len,
   input  logic [RMAX-1:0][W-1:0] load_bytes,
   output logic [W-1:0]          head,
   output logic                  avail
);
   localparam int  AW   = $clog2(DEPTH);
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("keyresp_fifo: DEPTH must be at least 2");
   end
   if (RMAX >= DEPTH) begin : g_bad_rmax
      $error("keyresp_fifo: reply must fit with room to spare");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rptr, wptr, rptr_nx, wptr_nx;
   logic [CW-1:0] count;
   logic          full, empty, do_push, do_pop;

   if (POW2) begin : g_wrap_pow2
      assign rptr_nx = rptr + AW'(1);
      assign wptr_nx = wptr + AW'(1);
   end else begin : g_wrap_cmp
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
   end

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full & ~load;
   assign do_pop  = pop & ~empty & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         wptr  <= '0;
         count <= '0;
      end else if (load) begin
         rptr  <= '0;
         wptr  <= AW'(load_len);
         count <= CW'(load_len);
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         for (int i = 0; i < RMAX; i++) mem[i] <= load_bytes[i];
      end else if (do_push) begin
         mem[wptr] <= push_data;
      end
   end

   assign head  = empty ? '0 : mem[rptr];
   assign avail = ~empty;

   // R2
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !load) |=> (full && $stable(rptr)));
   // R3
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !load) |=> (!avail && head == '0));
   // R4
   remain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count > CW'(1) && pop && !push && !load) |=> avail);
endmodule

// File: rtl/keyresp_lockflt.sv
module keyresp_lockflt (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic       release_ev,
   output logic       drop
);
   logic [1:0] st, st_nx;

   assign st_nx = release_ev ? (st ^ 2'b10) : (st ^ 2'b01);
   assign drop  = hit & (release_ev ? (st_nx == 2'd3) : (st_nx == 2'd2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st <= 2'd0;
      else if (hit) st <= st_nx;
   end

   // R10
   second_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !release_ev && st == 2'd3) |-> drop);
   // R10
   pair_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && release_ev && st == 2'd2) |-> !drop);
endmodule

// File: rtl/keyresp_cmd.sv
module keyresp_cmd
   import keyresp_pkg::*;
#(
   parameter int RMAX = KR_REPLY_MAX,
   parameter int LW   = KR_LEN_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  host_valid,
   input  kr_byte_t              host_byte,
   output logic                  load,
   output logic [LW-1:0]         load_len,
   output logic [RMAX-1:0][7:0]  load_bytes
);
   if (RMAX < 3) begin : g_bad_rmax
      $error("keyresp_cmd: replies need three byte slots");
   end

   logic light_arg;
   logic take;

   assign take = host_valid & enable;

   always_comb begin
      load       = 1'b0;
      load_len   = '0;
      load_bytes = '0;
      if (take && !light_arg) begin
         case (host_byte)
            KR_CMD_IDENT: begin
               load          = 1'b1;
               load_len      = LW'(3);
               load_bytes[0] = KR_ID_B0;
               load_bytes[1] = KR_ID_B1;
               load_bytes[2] = KR_ID_B2;
            end
            KR_CMD_LAYOUT0, KR_CMD_LAYOUT1: begin
               load          = 1'b1;
               load_len      = LW'(2);
               load_bytes[0] = KR_LAY_B0;
               load_bytes[1] = KR_LAY_B1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     light_arg <= 1'b0;
      else if (take)  light_arg <= light_arg ? 1'b0 : (host_byte == KR_CMD_LIGHTS);
   end

   // R8
   light_arg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (light_arg && take) |-> !load);
   // R11
   disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !load);
endmodule

// File: rtl/keyresp_top.sv
module keyresp_top
   import keyresp_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int NUM_LOCKS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 key_valid,
   input  logic [7:0]           key_code,
   input  logic                 key_release,
   input  logic [NUM_LOCKS-1:0] key_lock,
   input  logic                 host_valid,
   input  logic [7:0]           host_byte,
   input  logic                 pop,
   output logic [7:0]           pop_data,
   output logic                 data_avail
);
   if (NUM_LOCKS < 1) begin : g_bad_locks
      $error("keyresp_top: NUM_LOCKS must be at least 1");
   end

   logic                         load;
   logic [KR_LEN_W-1:0]          load_len;
   logic [KR_REPLY_MAX-1:0][7:0] load_bytes;
   logic                         key_go, push;
   logic [NUM_LOCKS-1:0]         drop_vec;
   kr_byte_t                     key_byte;

   keyresp_cmd #(.RMAX(KR_REPLY_MAX), .LW(KR_LEN_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .host_valid(host_valid), .host_byte(host_byte),
      .load(load), .load_len(load_len), .load_bytes(load_bytes)
   );

   assign key_go = key_valid & ~load;

   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
      keyresp_lockflt u_flt (
         .clk(clk), .rst_n(rst_n),
         .hit(key_go & key_lock[i]), .release_ev(key_release),
         .drop(drop_vec[i])
      );
   end

   assign key_byte = {key_release, key_code[6:0]};
   assign push     = key_go & ~(|drop_vec);

   keyresp_fifo #(.DEPTH(DEPTH), .W(8), .RMAX(KR_REPLY_MAX), .LW(KR_LEN_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(key_byte), .pop(pop),
      .load(load), .load_len(load_len), .load_bytes(load_bytes),
      .head(pop_data), .avail(data_avail)
   );

   // R10: at most one lock key identified per event
   lock_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> $onehot0(key_lock));
   // R6
   reply_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> data_avail);
endmodule

// File: tb/keyresp_top_bench.sv
`timescale 1ns/1ps
module keyresp_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b1;
   logic       key_valid = 1'b0;
   logic [7:0] key_code = '0;
   logic       key_release = 1'b0;
   logic [1:0] key_lock = '0;
   logic       host_valid = 1'b0;
   logic [7:0] host_byte = '0;
   logic       pop = 1'b0;
   logic [7:0] pop_data;
   logic       data_avail;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   keyresp_top u_keyresp_top (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .key_valid(key_valid), .key_code(key_code), .key_release(key_release),
      .key_lock(key_lock), .host_valid(host_valid), .host_byte(host_byte),
      .pop(pop), .pop_data(pop_data), .data_avail(data_avail)
   );

   // {op[1:0], data[7:0], release, lock[1:0], exp_avail, exp_head[7:0]}
   // op: 0 idle, 1 key event, 2 host byte, 3 pop
   localparam int NV = 29;
   localparam logic [21:0] VEC [0:NV-1] = '{
      {2'd1, 8'h1C, 1'b0, 2'b00, 1'b1, 8'h1C},  // R1 R5 press
      {2'd1, 8'h1C, 1'b1, 2'b00, 1'b1, 8'h1C},  // R1 order
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b1, 8'h9C},  // R4 R5 break byte
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 8'h00},  // R4 last out
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 8'h00},  // R3 pop empty
      {2'd1, 8'h9A, 1'b0, 2'b00, 1'b1, 8'h1A},  // R5 bit7 cleared
      {2'd2, 8'h01, 1'b0, 2'b00, 1'b1, 8'hFF},  // R6
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b1, 8'h04},  // R6
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b1, 8'h7F},  // R6
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 8'h00},  // R6 nothing more
      {2'd2, 8'h0E, 1'b0, 2'b00, 1'b0, 8'h00},  // R8 lights cmd
      {2'd2, 8'h01, 1'b0, 2'b00, 1'b0, 8'h00},  // R8 argument swallowed
      {2'd2, 8'h0F, 1'b0, 2'b00, 1'b1, 8'hFE},  // R7 R8 normal again
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b1, 8'h21},  // R7
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 8'h00},  // R7
      {2'd2, 8'h07, 1'b0, 2'b00, 1'b1, 8'hFE},  // R7
      {2'd2, 8'h05, 1'b0, 2'b00, 1'b1, 8'hFE},  // R9
      {2'd2, 8'h00, 1'b0, 2'b00, 1'b1, 8'hFE},  // R9
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b1, 8'h21},  // R9 queue intact
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 8'h00},  // R9
      {2'd1, 8'h77, 1'b0, 2'b01, 1'b1, 8'h77},  // R10 press -> 1 sent
      {2'd1, 8'h77, 1'b1, 2'b01, 1'b1, 8'h77},  // R10 release -> 3 dropped
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 8'h00},  // R10
      {2'd1, 8'h77, 1'b0, 2'b01, 1'b0, 8'h00},  // R10 press -> 2 dropped
      {2'd1, 8'h77, 1'b1, 2'b01, 1'b1, 8'hF7},  // R10 release -> 0 sent
      {2'd1, 8'h76, 1'b0, 2'b10, 1'b1, 8'hF7},  // R10 second lock own state
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b1, 8'h76},  // R10
      {2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 8'h00},  // R10
      {2'd1, 8'h76, 1'b1, 2'b10, 1'b0, 8'h00}   // R10 release -> 3 dropped
   };

   task automatic check(input string req, input logic exp_av, input logic [7:0] exp_hd);
      n_vec++;
      if (data_avail !== exp_av || pop_data !== exp_hd) begin
         n_bad++;
         $display("FAIL %s: avail=%0b data=%02h expected avail=%0b data=%02h",
                  req, data_avail, pop_data, exp_av, exp_hd);
      end
   endtask

   task automatic step(input logic [1:0] op, input logic [7:0] d,
                       input logic rel, input logic [1:0] lk);
      @(negedge clk);
      key_valid   = (op == 2'd1);
      host_valid  = (op == 2'd2);
      pop         = (op == 2'd3);
      key_code    = d;
      host_byte   = d;
      key_release = rel;
      key_lock    = lk;
      @(negedge clk);
      key_valid = 1'b0; host_valid = 1'b0; pop = 1'b0; key_lock = '0;
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12", 1'b0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", 1'b0, 8'h00);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][21:20], VEC[i][19:12], VEC[i][11], VEC[i][10:9]);
         check($sformatf("vector %0d", i), VEC[i][8], VEC[i][7:0]);
      end

      // R2 full queue drops the ninth byte
      for (int i = 0; i < 9; i++) step(2'd1, 8'h10 + 8'(i), 1'b0, 2'b00);
      check("R2", 1'b1, 8'h10);
      for (int i = 0; i < 8; i++) begin
         check("R2", 1'b1, 8'h10 + 8'(i));
         step(2'd3, 8'h00, 1'b0, 2'b00);
      end
      check("R2", 1'b0, 8'h00);

      // R11 host bytes ignored while disabled
      step(2'd1, 8'h33, 1'b0, 2'b00);
      enable = 1'b0;
      step(2'd2, 8'h01, 1'b0, 2'b00);
      check("R11", 1'b1, 8'h33);
      step(2'd2, 8'h0E, 1'b0, 2'b00);
      enable = 1'b1;
      step(2'd2, 8'h0F, 1'b0, 2'b00);
      check("R11", 1'b1, 8'hFE);
      step(2'd3, 8'h00, 1'b0, 2'b00);
      step(2'd3, 8'h00, 1'b0, 2'b00);
      check("R11", 1'b0, 8'h00);

      // R13 key event colliding with a reply load is lost
      @(negedge clk);
      host_valid = 1'b1; host_byte = 8'h0F;
      key_valid = 1'b1; key_code = 8'h44; key_release = 1'b0; key_lock = '0;
      @(negedge clk);
      host_valid = 1'b0; key_valid = 1'b0;
      check("R13", 1'b1, 8'hFE);
      step(2'd3, 8'h00, 1'b0, 2'b00);
      check("R13", 1'b1, 8'h21);
      step(2'd3, 8'h00, 1'b0, 2'b00);
      check("R13", 1'b0, 8'h00);

      // R12 reset clears light mode, lock state and the queue
      step(2'd1, 8'h58, 1'b0, 2'b01);
      step(2'd1, 8'h58, 1'b1, 2'b01);
      step(2'd2, 8'h0E, 1'b0, 2'b00);
      check("R12", 1'b1, 8'h58);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R12", 1'b0, 8'h00);
      step(2'd2, 8'h07, 1'b0, 2'b00);
      check("R12", 1'b1, 8'hFE);
      step(2'd3, 8'h00, 1'b0, 2'b00);
      step(2'd3, 8'h00, 1'b0, 2'b00);
      step(2'd1, 8'h58, 1'b0, 2'b01);
      check("R12", 1'b1, 8'h58);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule